// File: doc/BRIEF.md
# Link Configuration Register File

This block is the software-visible control store for a chip-to-chip link. A host reaches it over a simple word-wide register bus and uses it to turn the link on and off and to choose the link's operating modes. The block also reports the link's live and latched status. Its outputs drive the link logic directly. These outputs are a soft reset, the transmit and receive enables, the address-translation selects, a transmit control mode, a read-timeout enable, a 16-bit clock setting word and the grid coordinate of the attached chip.

Besides normal packet mode, the block offers a direct pin mode. When the transmit mode field selects it, the link drives its output pins from a host-written word. When the receive mode field selects it, the block copies the link's input pin values into a readable word on every cycle.

A debug word combines three things: the mailbox not-empty flag, a set of live FIFO and wait flags sampled at read time, and seven sticky full flags. A sticky flag stays set until the host writes the debug word.

Top module: `link_cfg_regs`

## Requirements
- R1: After reset, every register reads zero, except the core coordinate register (which holds the parameter DEF_COREID) and the version word (which holds the parameter VERSION). All control outputs are then low.
- R2: The register map uses word offsets, where word offset = byte address bits [ADDR_W-1:2]. Offset 0 is soft reset. Bit 0 of this register drives `link_reset`, where 1 holds the link in reset and 0 lets it run.
- R3: Offset 1 is the transmit setup register. Bit 0 drives `tx_enable`, bit 1 drives `tx_mmu_sel`, bits [7:4] drive `tx_ctrl_mode` and bit 8 drives `tx_timeout_en`. A read returns bits [8:0] as written.
- R4: Transmit setup bits [3:2] select the pin mode. `tx_pin_force` is high only when these bits are 01. The values 00, 10 and 11 leave it low. `tx_pin_word` always presents the pin output word.
- R5: Offset 2 is the receive setup register. Bit 0 drives `rx_enable` and bit 1 drives `rx_mmu_sel`. When bits [3:2] are 01, `rx_pin_capture` is high and the pin input word (offset 6) loads `rx_pin_word` on every clock. For any other value, the pin input word holds its value.
- R6: Offset 7 is the pin output word and offset 6 is the pin input word. Both use this layout: [7:0] data, bit 8 frame, bit 9 read-wait, bit 10 write-wait. Their bits [31:11] read as zero, and writes to offset 6 are ignored.
- R7: Offset 4 is the core coordinate register. Bits [5:0] drive `core_col` and bits [11:6] drive `core_row`.
- R8: Offset 5 always reads VERSION, and writes to it have no effect.
- R9: Offset 8 is the debug word. Bit 31 is `mbox_not_empty`, bits [30:8] are `live_flags` as sampled in the read cycle, bit 7 is zero and bits [6:0] are the sticky flags.
- R10: Sticky flag i sets in any cycle where `full_flags[i]` is high. It clears only on a write to offset 8 or on reset. If a set and a clear happen in the same cycle, the set wins.
- R11: Reads at offsets 9 and above return zero, and writes there change nothing.
- R12: A read (`bus_en` high, `bus_we` low) updates `bus_rdata` one clock later. In all other cycles `bus_rdata` holds its value.
- R13: Offset 3 holds a 16-bit clock setting, driven on `clk_cfg` and read back in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| link_reset | output | 1 | Soft reset to link |
| tx_enable | output | 1 | Transmit enable |
| tx_mmu_sel | output | 1 | Transmit table-based translation |
| tx_ctrl_mode | output | 4 | Transmit control mode |
| tx_timeout_en | output | 1 | Read timeout enable |
| rx_enable | output | 1 | Receive enable |
| rx_mmu_sel | output | 1 | Receive table-based translation |
| clk_cfg | output | 16 | Clock settings |
| core_col | output | 6 | Attached chip column |
| core_row | output | 6 | Attached chip row |
| tx_pin_force | output | 1 | Drive output pins from pin word |
| tx_pin_word | output | 11 | Pin output word |
| rx_pin_capture | output | 1 | Pin input capture active |
| rx_pin_word | input | 11 | Sampled link input pins |
| mbox_not_empty | input | 1 | Mailbox has data |
| live_flags | input | 23 | Live FIFO and wait flags |
| full_flags | input | 7 | Full pulses for sticky bits |

## Verification
The assertions assume the following about the inputs: the bus inputs carry no unknown values whenever reset is off, and `rx_pin_word` is stable where the capture check samples it. The low two address bits play no part in decoding. The stimulus drives every input on the falling clock edge from defined values and keeps the bus idle while reset settles. Random traffic covers all sixteen low word offsets, so both mapped and unmapped reads are exercised. The full pulses are sparse, which lets sticky bits be seen in both the held and the cleared state.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  localparam int NUM_REGS    = 9;
  localparam int OFF_RST     = 0;
  localparam int OFF_TXC     = 1;
  localparam int OFF_RXC     = 2;
  localparam int OFF_CLK     = 3;
  localparam int OFF_ID      = 4;
  localparam int OFF_VER     = 5;
  localparam int OFF_PIN_IN  = 6;
  localparam int OFF_PIN_OUT = 7;
  localparam int OFF_DBG     = 8;
  localparam int PIN_W       = 11;
  localparam int LIVE_W      = 23;
  localparam int STICKY_W    = 7;
  localparam int CLK_W       = 16;
  localparam int ID_W        = 12;
  localparam int TXC_W       = 9;
  localparam int RXC_W       = 4;
  localparam logic [1:0] PIN_MODE_DIRECT = 2'b01;
endpackage

// File: rtl/lcfg_rst_sync.sv
module lcfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/lcfg_decode.sv
module lcfg_decode #(
  parameter int IDX_W    = 6,
  parameter int NUM_REGS = 9
) (
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = (idx == IDX_W'(g));
  end
  assign hit = |sel;
endmodule

// File: rtl/lcfg_sticky.sv
module lcfg_sticky #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set_in,
  output logic [W-1:0] flags
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic nxt;
    logic en;

    always_comb begin
      en  = set_in[g] | clr;
      nxt = set_in[g] | (flags[g] & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags[g] <= 1'b0;
      else if (en) flags[g] <= nxt;
    end

    // R10: a full pulse always leaves the flag set
    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_in[g] |=> flags[g]);
    // R10: without a clear the flag never drops
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr) |=> flags[g]);
  end
endmodule

// File: rtl/link_cfg_regs.sv
module link_cfg_regs
  import lcfg_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] VERSION    = 32'h0000_0102,
  parameter logic [11:0] DEF_COREID = 12'h810
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              link_reset,
  output logic              tx_enable,
  output logic              tx_mmu_sel,
  output logic [3:0]        tx_ctrl_mode,
  output logic              tx_timeout_en,
  output logic              rx_enable,
  output logic              rx_mmu_sel,
  output logic [15:0]       clk_cfg,
  output logic [5:0]        core_col,
  output logic [5:0]        core_row,
  output logic              tx_pin_force,
  output logic [10:0]       tx_pin_word,
  output logic              rx_pin_capture,
  input  logic [10:0]       rx_pin_word,
  input  logic              mbox_not_empty,
  input  logic [22:0]       live_flags,
  input  logic [6:0]        full_flags
);
  localparam int IDX_W = ADDR_W - 2;

  logic                rst_s_n;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic [NUM_REGS-1:0] wr_sel;
  logic                rd_req;

  logic                rst_q;
  logic [TXC_W-1:0]    txc_q;
  logic [RXC_W-1:0]    rxc_q;
  logic [CLK_W-1:0]    clk_q;
  logic [ID_W-1:0]     id_q;
  logic [PIN_W-1:0]    pin_out_q;
  logic [PIN_W-1:0]    pin_in_q;
  logic [STICKY_W-1:0] sticky;
  logic [31:0]         rd_nxt;
  logic                unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

  lcfg_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  assign idx = bus_addr[ADDR_W-1:2];

  lcfg_decode #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_decode (
    .idx(idx), .sel(sel), .hit(hit)
  );

  always_comb begin
    wr_sel = sel & {NUM_REGS{bus_en & bus_we}};
    rd_req = bus_en & ~bus_we;
  end

  lcfg_sticky #(.W(STICKY_W)) u_sticky (
    .clk(clk), .rst_n(rst_s_n), .clr(wr_sel[OFF_DBG]),
    .set_in(full_flags), .flags(sticky)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rst_q     <= 1'b0;
      txc_q     <= '0;
      rxc_q     <= '0;
      clk_q     <= '0;
      id_q      <= DEF_COREID;
      pin_out_q <= '0;
    end else begin
      if (wr_sel[OFF_RST])     rst_q     <= bus_wdata[0];
      if (wr_sel[OFF_TXC])     txc_q     <= bus_wdata[TXC_W-1:0];
      if (wr_sel[OFF_RXC])     rxc_q     <= bus_wdata[RXC_W-1:0];
      if (wr_sel[OFF_CLK])     clk_q     <= bus_wdata[CLK_W-1:0];
      if (wr_sel[OFF_ID])      id_q      <= bus_wdata[ID_W-1:0];
      if (wr_sel[OFF_PIN_OUT]) pin_out_q <= bus_wdata[PIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)            pin_in_q <= '0;
    else if (rx_pin_capture) pin_in_q <= rx_pin_word;
  end

  always_comb begin
    rd_nxt = '0;
    if (sel[OFF_RST])     rd_nxt[0]          = rst_q;
    if (sel[OFF_TXC])     rd_nxt[TXC_W-1:0]  = txc_q;
    if (sel[OFF_RXC])     rd_nxt[RXC_W-1:0]  = rxc_q;
    if (sel[OFF_CLK])     rd_nxt[CLK_W-1:0]  = clk_q;
    if (sel[OFF_ID])      rd_nxt[ID_W-1:0]   = id_q;
    if (sel[OFF_VER])     rd_nxt             = VERSION;
    if (sel[OFF_PIN_IN])  rd_nxt[PIN_W-1:0]  = pin_in_q;
    if (sel[OFF_PIN_OUT]) rd_nxt[PIN_W-1:0]  = pin_out_q;
    if (sel[OFF_DBG])     rd_nxt = {mbox_not_empty, live_flags, 1'b0, sticky};
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_nxt;
  end

  always_comb begin
    link_reset     = rst_q;
    tx_enable      = txc_q[0];
    tx_mmu_sel     = txc_q[1];
    tx_pin_force   = (txc_q[3:2] == PIN_MODE_DIRECT);
    tx_ctrl_mode   = txc_q[7:4];
    tx_timeout_en  = txc_q[8];
    rx_enable      = rxc_q[0];
    rx_mmu_sel     = rxc_q[1];
    rx_pin_capture = (rxc_q[3:2] == PIN_MODE_DIRECT);
    clk_cfg        = clk_q;
    core_col       = id_q[5:0];
    core_row       = id_q[11:6];
    tx_pin_word    = pin_out_q;
  end

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));
  p_version_ro_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_en && !bus_we && idx == IDX_W'(OFF_VER)) |=> bus_rdata == VERSION);
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_en && !bus_we && !hit) |=> bus_rdata == 32'h0);
  p_pin_capture_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    rx_pin_capture |=> pin_in_q == $past(rx_pin_word));
endmodule

// File: tb/tb_link_cfg_regs.sv
`timescale 1ns/1ps
module tb_link_cfg_regs;
  localparam int          AW   = 8;
  localparam logic [31:0] VER  = 32'h0000_0102;
  localparam logic [11:0] DEFID = 12'h810;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic link_reset, tx_enable, tx_mmu_sel, tx_timeout_en, rx_enable, rx_mmu_sel;
  logic [3:0] tx_ctrl_mode;
  logic [15:0] clk_cfg;
  logic [5:0] core_col, core_row;
  logic tx_pin_force, rx_pin_capture;
  logic [10:0] tx_pin_word;
  logic [10:0] rx_pin_word = '0;
  logic mbox_not_empty = 1'b0;
  logic [22:0] live_flags = '0;
  logic [6:0] full_flags = '0;

  int errors = 0, checks = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  link_cfg_regs #(.ADDR_W(AW), .VERSION(VER), .DEF_COREID(DEFID)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .link_reset(link_reset), .tx_enable(tx_enable), .tx_mmu_sel(tx_mmu_sel),
    .tx_ctrl_mode(tx_ctrl_mode), .tx_timeout_en(tx_timeout_en),
    .rx_enable(rx_enable), .rx_mmu_sel(rx_mmu_sel), .clk_cfg(clk_cfg),
    .core_col(core_col), .core_row(core_row), .tx_pin_force(tx_pin_force),
    .tx_pin_word(tx_pin_word), .rx_pin_capture(rx_pin_capture),
    .rx_pin_word(rx_pin_word), .mbox_not_empty(mbox_not_empty),
    .live_flags(live_flags), .full_flags(full_flags)
  );

  // behavioural reference state
  logic        m_rst;
  logic [8:0]  m_tx;
  logic [3:0]  m_rx;
  logic [15:0] m_clk;
  logic [11:0] m_id;
  logic [10:0] m_dout, m_din;
  logic [6:0]  m_sticky;
  logic [31:0] m_rdata;
  int          last_off;

  function automatic logic [31:0] model_read(int off);
    case (off)
      0: return {31'b0, m_rst};
      1: return {23'b0, m_tx};
      2: return {28'b0, m_rx};
      3: return {16'b0, m_clk};
      4: return {20'b0, m_id};
      5: return VER;
      6: return {21'b0, m_din};
      7: return {21'b0, m_dout};
      8: return {mbox_not_empty, live_flags, 1'b0, m_sticky};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst <= 1'b0; m_tx <= '0; m_rx <= '0; m_clk <= '0; m_id <= DEFID;
      m_dout <= '0; m_din <= '0; m_sticky <= '0; m_rdata <= '0; last_off <= -1;
    end else begin
      int off;
      off = int'(bus_addr[AW-1:2]);
      if (bus_en && bus_we) begin
        case (off)
          0: m_rst  <= bus_wdata[0];
          1: m_tx   <= bus_wdata[8:0];
          2: m_rx   <= bus_wdata[3:0];
          3: m_clk  <= bus_wdata[15:0];
          4: m_id   <= bus_wdata[11:0];
          7: m_dout <= bus_wdata[10:0];
          default: ;
        endcase
      end
      m_sticky <= ((bus_en && bus_we && off == 8) ? 7'h0 : m_sticky) | full_flags;
      if (m_rx[3:2] == 2'b01) m_din <= rx_pin_word;
      if (bus_en && !bus_we) begin
        m_rdata  <= model_read(off);
        last_off <= off;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(int off);
    if (off == 5) return "R8";
    if (off == 6 || off == 7) return "R6";
    if (off == 8) return "R9/R10";
    if (off > 8) return "R11";
    if (off == 3) return "R13";
    return "R12";
  endfunction

  always @(posedge clk) begin
    #1;
    if (cmp_en) begin
      chk(bus_rdata === m_rdata, rd_tag(last_off), bus_rdata, m_rdata);
      chk(link_reset === m_rst, "R2", {31'b0, link_reset}, {31'b0, m_rst});
      chk({tx_timeout_en, tx_ctrl_mode, tx_mmu_sel, tx_enable} ===
          {m_tx[8], m_tx[7:4], m_tx[1], m_tx[0]}, "R3",
          {25'b0, tx_timeout_en, tx_ctrl_mode, tx_mmu_sel, tx_enable},
          {25'b0, m_tx[8], m_tx[7:4], m_tx[1], m_tx[0]});
      chk(tx_pin_force === (m_tx[3:2] == 2'b01) && tx_pin_word === m_dout, "R4",
          {20'b0, tx_pin_force, tx_pin_word},
          {20'b0, (m_tx[3:2] == 2'b01), m_dout});
      chk({rx_pin_capture, rx_mmu_sel, rx_enable} ===
          {(m_rx[3:2] == 2'b01), m_rx[1], m_rx[0]}, "R5",
          {29'b0, rx_pin_capture, rx_mmu_sel, rx_enable},
          {29'b0, (m_rx[3:2] == 2'b01), m_rx[1], m_rx[0]});
      chk(clk_cfg === m_clk, "R13", {16'b0, clk_cfg}, {16'b0, m_clk});
      chk({core_row, core_col} === m_id, "R7", {20'b0, core_row, core_col}, {20'b0, m_id});
    end
  end

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(off << 2); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int off);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(off << 2);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    // R1: reset state seen through outputs
    @(negedge clk);
    chk({core_row, core_col} === DEFID && !link_reset && !tx_enable &&
        !tx_pin_force && !rx_pin_capture && clk_cfg == 16'h0 && bus_rdata == 32'h0,
        "R1", {20'b0, core_row, core_col}, {20'b0, DEFID});
    for (int k = 0; k < 9; k++) rd(k);
    // R2 soft reset
    wr(0, 32'h1); rd(0); wr(0, 32'h0);
    // R3 / R4 transmit modes
    wr(1, 32'h1F3); rd(1);
    wr(7, 32'hFFFF_F5A3); rd(7);
    wr(1, 32'h0A5); wr(1, 32'h00C); wr(1, 32'h008); wr(1, 32'h004);
    // R5 / R6 receive capture
    rx_pin_word = 11'h3C1;
    wr(2, 32'h7);
    @(negedge clk); rx_pin_word = 11'h155;
    @(negedge clk); rx_pin_word = 11'h7FF;
    rd(6);
    wr(2, 32'hB);
    @(negedge clk); rx_pin_word = 11'h001;
    rd(6); wr(6, 32'hFFFF_FFFF); rd(6);
    // R13, R7, R8
    wr(3, 32'hABCD_1234); rd(3);
    wr(4, 32'hFFFF_FABC); rd(4);
    wr(5, 32'h0000_DEAD); rd(5);
    // R11 unmapped
    wr(9, 32'hFFFF_FFFF); wr(12, 32'h1234); rd(9); rd(63); rd(12);
    // R9 / R10 debug and sticky
    mbox_not_empty = 1'b1; live_flags = 23'h5A5A5A;
    @(negedge clk); full_flags = 7'h41;
    @(negedge clk); full_flags = 7'h00;
    rd(8);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(8 << 2); full_flags = 7'h04;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; full_flags = 7'h00;
    rd(8); wr(8, 32'h0); rd(8);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      bus_en = ($urandom % 3) != 0;
      bus_we = $urandom % 2;
      bus_addr = AW'(($urandom % 16) << 2);
      bus_wdata = $urandom;
      rx_pin_word = 11'($urandom);
      live_flags = 23'($urandom);
      mbox_not_empty = $urandom % 2;
      full_flags = (($urandom % 6) == 0) ? 7'($urandom) : 7'h0;
    end
    @(negedge clk);
    bus_en = 1'b0; full_flags = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule